// File: doc/BRIEF.md
# Three-Code Sequential Door Lock

The block is a door lock controller. The door opens only after three 4-bit codes are entered in a fixed order. The three expected codes arrive on input ports as plain values. Each entry is a 4-bit value with a one-cycle strobe. A small finite state machine tracks how far the user has got. It steers a selector that picks the stored code for the current step, and a bitwise comparator checks the entered value against that code.

A matching entry moves the lock one step forward, and the third match opens the door. A mismatching entry at any step sends the lock to a trapped error state. Once the lock is open or trapped, it stays there until a synchronous, active-high reset returns it to the first step. The entry interface is a valid-only stream. The block accepts an entry in every cycle and never applies back-pressure, so it has no ready output. The entered value is sampled only in a cycle where the strobe is high.

Top module: `combo_lock`

## Requirements
- R1: When `rst` is high at a rising clock edge, the lock goes to the first entry step and `door_open` is low from the next cycle.
- R2: `door_open` stays low while the lock has accepted fewer than three matching entries.
- R3: After matching entries for the first, second and third codes, `door_open` goes high in the cycle after the edge that samples the third entry.
- R4: In a cycle where `entry_valid` is low, the state holds. This is true whatever `entry_val` carries, even a value equal to the expected code.
- R5: A mismatching entry at any step traps the lock closed. Later entries, correct or not, leave `door_open` low until reset.
- R6: Once open, the lock stays open under any further entries until reset.
- R7: Reset overrides every other input. If `rst` and `entry_valid` are high together, the entry is discarded, and the next accepted entry is compared with the first code. Reset also leaves the open state and the error state.
- R8: An entry matches only if all 4 bits equal the selected code. A difference in any single bit is a mismatch.
- R9: Step one compares against `code_1`, step two against `code_2` and step three against `code_3`. Each code is read from its port in the cycle the entry is sampled. Entering the codes in another order is a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| entry_val | input | 4 | Entered code value |
| entry_valid | input | 1 | One-cycle strobe marking `entry_val` as a new entry |
| code_1 | input | 4 | Code expected at step one |
| code_2 | input | 4 | Code expected at step two |
| code_3 | input | 4 | Code expected at step three |
| door_open | output | 1 | High only while the lock is open |

## Verification
The assertions assume that `entry_valid` and `entry_val` are known at every clock edge, and that the code ports are stable in any cycle where an entry is sampled. The properties are written against the state and the comparator result in that same cycle. The bench drives every input at the falling edge, holds the codes constant except for one deliberate change between entries, and starts every run with reset asserted. This keeps every property inside those assumptions.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  parameter int CODE_W    = 4;
  parameter int NUM_CODES = 3;
  localparam int SEL_W    = $clog2(NUM_CODES);

  typedef enum logic [2:0] {
    ST_STEP1 = 3'd0,
    ST_STEP2 = 3'd1,
    ST_STEP3 = 3'd2,
    ST_OPEN  = 3'd3,
    ST_ERR   = 3'd4
  } lock_state_e;
endpackage

// File: rtl/code_select.sv
module code_select
  import combo_lock_pkg::*;
#(
  parameter int W = CODE_W,
  parameter int N = NUM_CODES,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] codes,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   picked
);
  logic [N-1:0][W-1:0] gated;

  // one-hot decode, AND each code with its select line, then OR them together
  for (genvar i = 0; i < N; i++) begin : g_leg
    logic hit;
    assign hit      = (sel == SW'(i));
    assign gated[i] = codes[i*W +: W] & {W{hit}};
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < N; i++) picked = picked | gated[i];
  end
endmodule

// File: rtl/code_compare.sv
module code_compare
  import combo_lock_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         same
);
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = ~(a[i] ^ b[i]);
  end

  assign same = &bit_eq;
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import combo_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              entry_valid,
  input  logic              match,
  output lock_state_e       state,
  output logic [SEL_W-1:0]  sel,
  output logic              door_open
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STEP1: if (entry_valid) state_d = match ? ST_STEP2 : ST_ERR;
      ST_STEP2: if (entry_valid) state_d = match ? ST_STEP3 : ST_ERR;
      ST_STEP3: if (entry_valid) state_d = match ? ST_OPEN  : ST_ERR;
      ST_OPEN:  state_d = ST_OPEN;
      ST_ERR:   state_d = ST_ERR;
      default:  state_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_STEP1;
    else     state_q <= state_d;
  end

  // select follows the step; terminal states park on the first code
  always_comb begin
    unique case (state_q)
      ST_STEP2: sel = SEL_W'(1);
      ST_STEP3: sel = SEL_W'(2);
      default:  sel = SEL_W'(0);
    endcase
  end

  assign door_open = (state_q == ST_OPEN);
  assign state     = state_q;
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] entry_val,
  input  logic              entry_valid,
  input  logic [CODE_W-1:0] code_1,
  input  logic [CODE_W-1:0] code_2,
  input  logic [CODE_W-1:0] code_3,
  output logic              door_open
);
  logic [NUM_CODES*CODE_W-1:0] code_bus;
  logic [SEL_W-1:0]            code_sel;
  logic [CODE_W-1:0]           cur_code;
  logic                        code_match;
  lock_state_e                 lock_state;

  assign code_bus = {code_3, code_2, code_1};

  code_select #(.W(CODE_W), .N(NUM_CODES)) u_sel (
    .codes  (code_bus),
    .sel    (code_sel),
    .picked (cur_code)
  );

  code_compare #(.W(CODE_W)) u_cmp (
    .a    (entry_val),
    .b    (cur_code),
    .same (code_match)
  );

  lock_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .entry_valid (entry_valid),
    .match       (code_match),
    .state       (lock_state),
    .sel         (code_sel),
    .door_open   (door_open)
  );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
  import combo_lock_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        entry_valid,
  input logic        match,
  input lock_state_e state,
  input logic        door_open
);
  logic in_entry;
  assign in_entry = (state == ST_STEP1) || (state == ST_STEP2) || (state == ST_STEP3);

  p_reset_closes_r1: assert property (@(posedge clk) rst |=> (!door_open && state == ST_STEP1));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (in_entry && !entry_valid) |=> $stable(state));

  p_step1_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STEP1 && entry_valid && match) |=> state == ST_STEP2);

  p_step3_open_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STEP3 && entry_valid && match) |=> door_open);

  p_mismatch_trap_r5: assert property (@(posedge clk) disable iff (rst)
    (in_entry && entry_valid && !match) |=> state == ST_ERR);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERR) |=> (state == ST_ERR && !door_open));

  p_open_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    door_open |=> door_open);

  p_open_needs_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(door_open) |-> $past(entry_valid));
endmodule

bind combo_lock combo_lock_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .entry_valid (entry_valid),
  .match       (code_match),
  .state       (lock_state),
  .door_open   (door_open)
);

// File: tb/test_combo_lock.sv
module test_combo_lock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] entry_val = '0;
  logic       entry_valid = 1'b0;
  logic [3:0] code_1 = 4'h3;
  logic [3:0] code_2 = 4'hA;
  logic [3:0] code_3 = 4'h5;
  logic       door_open;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  combo_lock i_combo_lock (
    .clk(clk), .rst(rst), .entry_val(entry_val), .entry_valid(entry_valid),
    .code_1(code_1), .code_2(code_2), .code_3(code_3), .door_open(door_open)
  );

  // vector: {rst, valid, value[3:0], expected door_open, requirement number[3:0]}
  localparam int NV = 17;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'h0, 1'b0, 4'd1}, // R1 reset -> closed
    {1'b0, 1'b1, 4'h3, 1'b0, 4'd2}, // R2 first code accepted, still closed
    {1'b0, 1'b0, 4'hA, 1'b0, 4'd4}, // R4 matching value without strobe ignored
    {1'b0, 1'b1, 4'hA, 1'b0, 4'd2}, // R2 second code
    {1'b0, 1'b0, 4'h0, 1'b0, 4'd4}, // R4 idle
    {1'b0, 1'b1, 4'h5, 1'b1, 4'd3}, // R3 third code opens
    {1'b0, 1'b1, 4'h0, 1'b1, 4'd6}, // R6 wrong entry while open
    {1'b0, 1'b0, 4'h0, 1'b1, 4'd6}, // R6 idle while open
    {1'b1, 1'b1, 4'h3, 1'b0, 4'd7}, // R7 reset with strobe: entry discarded
    {1'b0, 1'b1, 4'h3, 1'b0, 4'd7}, // R7 first code still expected
    {1'b0, 1'b1, 4'hA, 1'b0, 4'd7},
    {1'b0, 1'b1, 4'h5, 1'b1, 4'd7}, // R7 opens
    {1'b1, 1'b0, 4'h0, 1'b0, 4'd7}, // R7 reset leaves open
    {1'b0, 1'b1, 4'hA, 1'b0, 4'd9}, // R9 second code first -> error
    {1'b0, 1'b1, 4'h3, 1'b0, 4'd5}, // R5 trapped
    {1'b0, 1'b1, 4'hA, 1'b0, 4'd5},
    {1'b0, 1'b1, 4'h5, 1'b0, 4'd5}  // R5 full correct sequence after error stays closed
  };

  task automatic check(input logic exp, input string req);
    n_tests++;
    if (door_open !== exp) begin
      n_fail++;
      $display("FAIL %s door_open=%b expected=%b", req, door_open, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, sample at the next falling edge
  task automatic drive(input logic r, input logic v, input logic [3:0] val);
    rst = r; entry_valid = v; entry_val = val;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; entry_valid = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    foreach (VEC[i]) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8:5]);
      check(VEC[i][4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // R5 / R8: error at each of the three steps, single flipped bit
    for (int k = 0; k < 3; k++) begin
      logic [3:0] seq [3];
      seq[0] = code_1; seq[1] = code_2; seq[2] = code_3;
      drive(1'b1, 1'b0, 4'h0);
      for (int j = 0; j < 3; j++) begin
        drive(1'b0, 1'b1, (j == k) ? (seq[j] ^ (4'h1 << j)) : seq[j]);
        drive(1'b0, 1'b0, 4'h0); // R4 idle gap between entries
      end
      check(1'b0, $sformatf("R8 bit error at step %0d", k + 1));
      drive(1'b0, 1'b1, code_1);
      check(1'b0, "R5 stays closed after error");
    end

    // R1 reset leaves error state, then normal opening
    drive(1'b1, 1'b0, 4'h0);
    check(1'b0, "R1 closed after reset from error");
    drive(1'b0, 1'b1, code_1);
    drive(1'b0, 1'b1, code_2);
    check(1'b0, "R2 two codes only");
    drive(1'b0, 1'b1, code_3);
    check(1'b1, "R3 open after full sequence");

    // R9 code ports read at entry time
    drive(1'b1, 1'b0, 4'h0);
    code_1 = 4'hC; code_2 = 4'h0; code_3 = 4'hF;
    drive(1'b0, 1'b1, 4'hC);
    drive(1'b0, 1'b1, 4'h0);
    drive(1'b0, 1'b1, 4'hF);
    check(1'b1, "R9 new codes accepted");
    drive(1'b1, 1'b0, 4'h0);
    drive(1'b0, 1'b1, 4'h3);
    drive(1'b0, 1'b1, 4'hA);
    drive(1'b0, 1'b1, 4'h5);
    check(1'b0, "R9 old codes rejected");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule